// File: doc/BRIEF.md
# Slice-Pipelined Ripple-Carry Adder

This block adds two unsigned operands at a rate of one pair per clock. It keeps only one adder cell per bit position. The ripple-carry chain is cut into slices of `SLICE_BITS` positions. Each slice is one pipeline stage. A stage adds its own operand bits to the carry registered by the stage before it. It then registers two things for the next stage: the carry leaving the slice and the operand bits that have not been used yet. The store of unused operand bits shrinks by one slice at every stage. Inside a slice the carry ripples through without being registered.

The sum bits leave the stages in skewed order, least significant slice first. A triangle of delay registers holds each slice's sum bits until the most significant slice has finished. After that, the whole `WIDTH+1`-bit sum and its valid flag are presented together. The carry out of the last stage becomes the top sum bit. If `WIDTH` is not a multiple of `SLICE_BITS`, the last stage is narrower and handles the remaining bits.

Top module: `skew_ripple_adder`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_sum` are 0. After reset is released, `out_valid` stays 0 until the first accepted pair emerges.
- R2: When `out_valid` is 1, `out_sum` equals `in_a + in_b` as an unsigned `WIDTH+1`-bit value. Bit `WIDTH` is the carry out of the most significant position.
- R3: Latency is S = ceil(WIDTH/SLICE_BITS) rising edges. A pair sampled with `in_valid` high at edge E shows on `out_sum` with `out_valid` high in the cycle after edge E+S-1, for exactly one cycle.
- R4: A new pair can be accepted on every clock. Back-to-back pairs give back-to-back results, in the order they were accepted.
- R5: A cycle with `in_valid` low gives a cycle with `out_valid` low S edges later. Operand values presented in such a cycle change no valid result.
- R6: A carry generated in the least significant position travels through every stage boundary. For example, all-ones plus one gives a result with only bit `WIDTH` set.
- R7: Two all-ones operands give 2^(WIDTH+1)-2. A valid `out_sum` is never all ones.
- R8: When `WIDTH` is not a multiple of `SLICE_BITS`, the last stage handles the remaining WIDTH mod SLICE_BITS bits. For WIDTH=10 and SLICE_BITS=4 there are three stages, so the latency is 3.
- R9: With `SLICE_BITS`=1, each stage handles one bit position. Weight 0 uses a half adder with no carry input, and the latency is `WIDTH` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the operand pair on `in_a`/`in_b` as one to add |
| in_a | input | WIDTH | First unsigned operand |
| in_b | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | Marks `out_sum` as the result of an accepted pair |
| out_sum | output | WIDTH+1 | Deskewed sum; the top bit is the final carry |

## Verification
The bound checker keeps its own history of input sums, S deep. On every cycle it checks four things:
- that `out_valid` lines up with the valid strobe from S edges earlier;
- that each valid result equals the recorded sum;
- that reset holds the outputs idle;
- that no valid result is ever all ones.

Other behaviours can only be shown by the bench's scenarios. These are:
- a carry rippling across every slice boundary;
- the saturating all-ones case;
- interleaved bubbles carrying junk operands;
- the narrower final stage of an uneven split;
- the one-bit-per-stage configuration with its half-adder LSB and latency of WIDTH.

The bench runs three instances with different widths and slice sizes to cover these.

// File: rtl/skra_pkg.sv
package skra_pkg;

    // number of pipeline stages for a given operand width and slice size
    function automatic int stage_count(input int width, input int slice);
        return (width + slice - 1) / slice;
    endfunction

    // bit positions handled by stage k (last stage may be narrower)
    function automatic int slice_width(input int k, input int width, input int slice);
        int remain;
        remain = width - k * slice;
        return (remain < slice) ? remain : slice;
    endfunction

    // operand bits each operand forwards from stage k to stage k+1
    function automatic int fwd_width(input int k, input int width, input int slice);
        int remain;
        remain = width - (k + 1) * slice;
        return (remain > 0) ? remain : 0;
    endfunction

    // offset of stage k's forwarded bits inside the flat forwarding store
    function automatic int fwd_offset(input int k, input int width, input int slice);
        int acc;
        acc = 0;
        for (int j = 0; j < k; j++) begin
            acc += fwd_width(j, width, slice);
        end
        return acc;
    endfunction

    // total forwarding store per operand
    function automatic int fwd_total(input int width, input int slice);
        return fwd_offset(stage_count(width, slice) - 1, width, slice);
    endfunction

endpackage

// File: rtl/rca_cell.sv
module rca_cell #(
    parameter bit HALF = 1'b0
) (
    input  logic a,
    input  logic b,
    input  logic ci,
    output logic s,
    output logic co
);

    if (HALF) begin : g_half
        // weight-0 position: no carry enters the chain
        logic unused_ci;
        assign unused_ci = ci;
        assign s         = a ^ b;
        assign co        = a & b;
    end else begin : g_full
        assign s  = a ^ b ^ ci;
        assign co = (a & b) | (ci & (a ^ b));
    end

endmodule

// File: rtl/rca_slice.sv
module rca_slice #(
    parameter int WIDTH    = 4,
    parameter bit HALF_LSB = 1'b0
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    logic [WIDTH:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        rca_cell #(
            .HALF(HALF_LSB && (i == 0))
        ) u_cell (
            .a (a[i]),
            .b (b[i]),
            .ci(chain[i]),
            .s (sum[i]),
            .co(chain[i+1])
        );
    end

    assign cout = chain[WIDTH];

endmodule

// File: rtl/rca_deskew.sv
module rca_deskew #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] pipe_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pipe_q[i] <= '0;
            end
        end else begin
            pipe_q[0] <= d;
            for (int i = 1; i < DEPTH; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign q = pipe_q[DEPTH-1];

endmodule

// File: rtl/skew_ripple_adder.sv
module skew_ripple_adder #(
    parameter int WIDTH      = 16,
    parameter int SLICE_BITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic             out_valid,
    output logic [WIDTH:0]   out_sum
);

    import skra_pkg::*;

    localparam int NSTG     = stage_count(WIDTH, SLICE_BITS);
    localparam int FW_TOTAL = fwd_total(WIDTH, SLICE_BITS);
    localparam int FW_BITS  = (FW_TOTAL > 0) ? FW_TOTAL : 1;

    // flat stores of operand bits not yet consumed, one segment per boundary
    logic [FW_BITS-1:0] fw_a_q;
    logic [FW_BITS-1:0] fw_b_q;
    // carry and valid leaving each stage; the last entries feed the output
    logic               carry_q [NSTG];
    logic               vld_q   [NSTG];
    logic [WIDTH-1:0]   sum_aligned;

    for (genvar k = 0; k < NSTG; k++) begin : g_stg
        localparam int LO      = k * SLICE_BITS;
        localparam int SW      = slice_width(k, WIDTH, SLICE_BITS);
        localparam int REM     = WIDTH - LO;
        localparam int OFF_IN  = (k > 0) ? fwd_offset(k - 1, WIDTH, SLICE_BITS) : 0;
        localparam int OFF_OUT = fwd_offset(k, WIDTH, SLICE_BITS);
        localparam int FWW     = fwd_width(k, WIDTH, SLICE_BITS);

        logic [REM-1:0] a_in;
        logic [REM-1:0] b_in;
        logic           c_in;
        logic           v_in;
        logic [SW-1:0]  s_comb;
        logic           co_comb;

        if (k == 0) begin : g_entry
            assign a_in = in_a;
            assign b_in = in_b;
            assign c_in = 1'b0;
            assign v_in = in_valid;
        end else begin : g_inner
            assign a_in = fw_a_q[OFF_IN +: REM];
            assign b_in = fw_b_q[OFF_IN +: REM];
            assign c_in = carry_q[k-1];
            assign v_in = vld_q[k-1];
        end

        rca_slice #(
            .WIDTH   (SW),
            .HALF_LSB(k == 0)
        ) u_slice (
            .a   (a_in[SW-1:0]),
            .b   (b_in[SW-1:0]),
            .cin (c_in),
            .sum (s_comb),
            .cout(co_comb)
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                carry_q[k] <= 1'b0;
                vld_q[k]   <= 1'b0;
            end else begin
                carry_q[k] <= co_comb;
                vld_q[k]   <= v_in;
            end
        end

        if (k < NSTG - 1) begin : g_fwd
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    fw_a_q[OFF_OUT +: FWW] <= '0;
                    fw_b_q[OFF_OUT +: FWW] <= '0;
                end else begin
                    fw_a_q[OFF_OUT +: FWW] <= a_in[REM-1:SW];
                    fw_b_q[OFF_OUT +: FWW] <= b_in[REM-1:SW];
                end
            end
        end

        // early slices wait longer so all slices land on the same edge
        rca_deskew #(
            .WIDTH(SW),
            .DEPTH(NSTG - k)
        ) u_deskew (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (s_comb),
            .q    (sum_aligned[LO +: SW])
        );
    end

    if (NSTG == 1) begin : g_single
        logic unused_fw;
        assign fw_a_q    = '0;
        assign fw_b_q    = '0;
        assign unused_fw = ^{fw_a_q, fw_b_q};
    end

    assign out_sum   = {carry_q[NSTG-1], sum_aligned};
    assign out_valid = vld_q[NSTG-1];

endmodule

// File: rtl/skew_ripple_adder_chk.sv
module skew_ripple_adder_chk #(
    parameter int WIDTH      = 16,
    parameter int SLICE_BITS = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] in_a,
    input logic [WIDTH-1:0] in_b,
    input logic             out_valid,
    input logic [WIDTH:0]   out_sum
);

    localparam int LAT = skra_pkg::stage_count(WIDTH, SLICE_BITS);

    logic           hist_v [LAT];
    logic [WIDTH:0] hist_s [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) begin
                hist_v[i] <= 1'b0;
                hist_s[i] <= '0;
            end
        end else begin
            hist_v[0] <= in_valid;
            hist_s[0] <= {1'b0, in_a} + {1'b0, in_b};
            for (int i = 1; i < LAT; i++) begin
                hist_v[i] <= hist_v[i-1];
                hist_s[i] <= hist_s[i-1];
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_idle_r1: assert (out_valid == 1'b0 && out_sum == '0)
                else $error("R1: outputs not idle in reset");
        end
    end

    p_sum_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sum == hist_s[LAT-1])
        else $error("R2: sum mismatch");

    p_valid_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == hist_v[LAT-1])
        else $error("R3: valid not aligned to latency");

    p_no_all_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_sum != '1)
        else $error("R7: impossible all-ones sum");

endmodule

bind skew_ripple_adder skew_ripple_adder_chk #(
    .WIDTH     (WIDTH),
    .SLICE_BITS(SLICE_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_a     (in_a),
    .in_b     (in_b),
    .out_valid(out_valid),
    .out_sum  (out_sum)
);

// File: tb/skew_ripple_adder_tb_top.sv
`timescale 1ns/1ps
module skew_ripple_adder_tb_top;

    // latencies from R3: ceil(width/slice)
    localparam int LAT_M = (16 + 4 - 1) / 4;
    localparam int LAT_O = (10 + 4 - 1) / 4;
    localparam int LAT_B = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vin = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;

    logic        m_v, o_v, b_v;
    logic [16:0] m_s;
    logic [10:0] o_s;
    logic [6:0]  b_s;

    typedef struct packed {
        logic        v;
        logic [16:0] s;
    } exp_t;

    exp_t  q_m[$], q_o[$], q_b[$];
    string t_m[$], t_o[$], t_b[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    always #2 clk = ~clk;

    skew_ripple_adder #(.WIDTH(16), .SLICE_BITS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_a(a), .in_b(b),
        .out_valid(m_v), .out_sum(m_s));

    skew_ripple_adder #(.WIDTH(10), .SLICE_BITS(4)) dut_odd_i (
        .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_a(a[9:0]), .in_b(b[9:0]),
        .out_valid(o_v), .out_sum(o_s));

    skew_ripple_adder #(.WIDTH(6), .SLICE_BITS(1)) dut_bit_i (
        .clk(clk), .rst_n(rst_n), .in_valid(vin), .in_a(a[5:0]), .in_b(b[5:0]),
        .out_valid(b_v), .out_sum(b_s));

    task automatic chk(input string req, input string what,
                       input logic [16:0] act, input logic [16:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare one instance against its reference queue entry
    task automatic cmp(input string inst_req, input int lat, input int qsize,
                       input exp_t e, input string tag,
                       input logic v, input logic [16:0] s);
        if (qsize < lat) begin
            chk({"R1/", inst_req}, "warm-up valid", {16'd0, v}, 17'd0);
        end else begin
            chk({"R3/", inst_req}, "valid", {16'd0, v}, {16'd0, e.v});
            if (e.v) chk({tag, "/", inst_req}, "sum", s, e.s);
        end
    endtask

    task automatic step(input logic nv, input logic [15:0] na,
                        input logic [15:0] nb, input string tag);
        exp_t e;
        @(negedge clk);
        e = '0;
        if (q_m.size() == LAT_M) begin
            e = q_m.pop_front();
            cmp("R2", LAT_M, LAT_M, e, t_m.pop_front(), m_v, m_s);
        end else cmp("R2", LAT_M, q_m.size(), e, "", m_v, m_s);
        e = '0;
        if (q_o.size() == LAT_O) begin
            e = q_o.pop_front();
            cmp("R8", LAT_O, LAT_O, e, t_o.pop_front(), o_v, {6'd0, o_s});
        end else cmp("R8", LAT_O, q_o.size(), e, "", o_v, {6'd0, o_s});
        e = '0;
        if (q_b.size() == LAT_B) begin
            e = q_b.pop_front();
            cmp("R9", LAT_B, LAT_B, e, t_b.pop_front(), b_v, {10'd0, b_s});
        end else cmp("R9", LAT_B, q_b.size(), e, "", b_v, {10'd0, b_s});
        vin = nv;
        a   = na;
        b   = nb;
        q_m.push_back('{v: nv, s: {1'b0, na} + {1'b0, nb}});
        q_o.push_back('{v: nv, s: {7'd0, na[9:0]} + {7'd0, nb[9:0]}});
        q_b.push_back('{v: nv, s: {11'd0, na[5:0]} + {11'd0, nb[5:0]}});
        t_m.push_back(tag);
        t_o.push_back(tag);
        t_b.push_back(tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        int lat_seen;
        // R1: outputs idle while reset is held, with active inputs
        vin = 1'b1;
        a   = 16'hFFFF;
        b   = 16'h1234;
        repeat (3) begin
            @(negedge clk);
            chk("R1", "reset valid", {14'd0, m_v, o_v, b_v}, 17'd0);
            chk("R1", "reset sum", m_s | {6'd0, o_s} | {10'd0, b_s}, 17'd0);
        end
        vin   = 1'b0;
        a     = '0;
        b     = '0;
        rst_n = 1'b1;

        // R2: assorted operand patterns
        step(1'b1, 16'h0000, 16'h0000, "R2");
        step(1'b1, 16'h0001, 16'h0001, "R2");
        step(1'b1, 16'h1234, 16'h4321, "R2");
        step(1'b1, 16'hAAAA, 16'h5555, "R2");
        step(1'b1, 16'h8000, 16'h8000, "R2");
        // R6: carry rippling across every slice boundary
        step(1'b1, 16'hFFFF, 16'h0001, "R6");
        step(1'b1, 16'h0FFF, 16'h0001, "R6");
        step(1'b1, 16'h03FF, 16'h0001, "R6");
        step(1'b1, 16'h003F, 16'h0001, "R6");
        // R7: both operands all ones
        step(1'b1, 16'hFFFF, 16'hFFFF, "R7");
        // R4: back-to-back stream
        for (int i = 0; i < 60; i++) begin
            step(1'b1, 16'($urandom()), 16'($urandom()), "R4");
        end
        // R5: bubbles carrying junk operands
        for (int i = 0; i < 40; i++) begin
            step(i[0], 16'($urandom()), 16'($urandom()), "R5");
        end
        for (int i = 0; i < LAT_B + 2; i++) begin
            step(1'b0, 16'($urandom()), 16'($urandom()), "R5");
        end

        // R3: single pair, count edges until the result shows on the main instance
        @(negedge clk);
        vin = 1'b1;
        a   = 16'h7FFF;
        b   = 16'h0001;
        q_m.delete(); q_o.delete(); q_b.delete();
        t_m.delete(); t_o.delete(); t_b.delete();
        lat_seen = 0;
        @(negedge clk);
        vin = 1'b0;
        lat_seen = 1;
        while (!m_v && lat_seen < 20) begin
            @(negedge clk);
            lat_seen++;
        end
        chk("R3", "latency", 17'(lat_seen), 17'(LAT_M));
        chk("R3", "latency sum", m_s, 17'h08000);
        @(negedge clk);
        chk("R3", "single-cycle valid", {16'd0, m_v}, 17'd0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule